// File: doc/BRIEF.md
# Dual Q15 Multiply-Accumulate Unit

This block is the arithmetic core of a two-lane SIMD multiply-accumulate operation. Each lane takes one signed 16-bit halfword from each of two 32-bit source words, multiplies them, and adds the product to a 32-bit accumulator or subtracts it. Each lane has its own accumulator. The operation code picks one of three variants:

- **Integer:** the raw product is accumulated.
- **Wide fractional:** the product is doubled (Q15 scaling) and each lane returns a full 32-bit result.
- **Packed fractional:** the product is doubled, the result is rounded, and the two rounded upper halves are merged into one word.

A control word decides whether rounding happens. In the packed variant it also decides whether ties round to even.

The register file and the decoder sit outside the block. They present the operands for one cycle with `issue` high. One cycle later the block returns the result words with their write enables and a one-cycle `out_valid` pulse.

The output stage is a two-state machine:

- **ST_IDLE:** nothing to deliver. The transition *accept* (issue with a recognised code) moves it to ST_HOLD.
- **ST_HOLD:** the registered result is presented. *accept* keeps it in ST_HOLD, and *drain* (no accepted operation) returns it to ST_IDLE.

Top module: `dmac_q15`

## Requirements
- R1: Only the operation codes 0x0A (integer), 0x0F (wide fractional) and 0x0B (packed fractional) are accepted when `issue` is high. Any other code, or `issue` low, gives `out_valid`, `we_a` and `we_d` all low in the following cycle.
- R2: `sel` chooses the halfwords for each lane, where hi is bits 31:16 and lo is bits 15:0. The value 0 gives lane A hi(b)*hi(c) and lane D lo(b)*lo(c). The value 1 gives lane A lo(b)*hi(c) and lane D hi(b)*lo(c). The value 2 gives hi(b)*hi(c) in both lanes. The value 3 gives lo(b)*lo(c) in both lanes. The halfwords are signed.
- R3: In the integer variant each lane result is its accumulator plus or minus the signed product, modulo 2^32, with no saturation.
- R4: In both fractional variants each product is shifted left by one bit, modulo 2^32, before it is accumulated.
- R5: `acc_pat[1]` set makes lane A subtract its product, and `acc_pat[0]` set makes lane D subtract. A clear bit means add.
- R6: Rounding happens only when `ctrl[1]` is set. Otherwise the fractional lane results are not rounded.
- R7: In the wide fractional variant, rounding adds 0x8000 to both lane results whatever the value of `ctrl[2]`.
- R8: In the packed variant with `ctrl[1]` and `ctrl[2]` set, 0x8000 is added to both lanes unconditionally.
- R9: In the packed variant with `ctrl[1]` set and `ctrl[2]` clear, a lane whose low 17 bits equal exactly 0x08000 receives no addition (round half to even). Every other lane receives 0x8000.
- R10: The packed variant returns a single word. Its bits 31:16 are bits 31:16 of lane A and its bits 15:0 are bits 31:16 of lane D. This word appears on `res_a` with `we_a` high and `we_d` low.
- R11: The integer and wide variants return lane A on `res_a` and lane D on `res_d`, with both write enables high.
- R12: Results and write enables are registered. They appear one cycle after acceptance, together with a one-cycle `out_valid` pulse per accepted operation. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Operands and code are presented this cycle |
| op | input | 6 | Operation code (0x0A, 0x0F or 0x0B) |
| sel | input | 2 | Halfword selection pattern |
| acc_pat | input | 2 | Add/subtract pattern, bit 1 for lane A and bit 0 for lane D |
| ctrl | input | 32 | Control word: bit 1 enables rounding, bit 2 forces the bias |
| src_b | input | 32 | First multiplicand word |
| src_c | input | 32 | Second multiplicand word |
| acc_a | input | 32 | Lane A accumulator |
| acc_d | input | 32 | Lane D accumulator |
| out_valid | output | 1 | Result pulse, one cycle per accepted operation |
| res_a | output | 32 | Lane A result or packed word |
| res_d | output | 32 | Lane D result |
| we_a | output | 1 | Write enable for the first destination |
| we_d | output | 1 | Write enable for the second destination |

## Verification
On every cycle, the assertions check the following:
- the state machine's acceptance and drain behaviour;
- which write enables each variant raises;
- that a doubled product always has a zero LSB;
- that a rounding stage changes a lane only when rounding is enabled, and then by exactly 0x8000 or, for an even-tie lane, by nothing.

Only the bench scenarios can show the numeric results against an independent model. These include the halfword selection patterns, the sign of the accumulation, the wrap of a doubled -32768 squared, tie detection at the 17-bit boundary, and the layout of the packed word.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [5:0] {
        OP_INT  = 6'h0A,
        OP_PACK = 6'h0B,
        OP_WIDE = 6'h0F
    } dmac_op_e;

    typedef enum logic [1:0] {
        SEL_HH_LL = 2'd0,
        SEL_LH_HL = 2'd1,
        SEL_HH_HH = 2'd2,
        SEL_LL_LL = 2'd3
    } dmac_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } dmac_state_e;

    localparam int CTRL_RND_BIT  = 1;
    localparam int CTRL_BIAS_BIT = 2;
endpackage

// File: rtl/dmac_opsel.sv
module dmac_opsel
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] src_c,
    output logic [HALF_W-1:0] a_x,
    output logic [HALF_W-1:0] a_y,
    output logic [HALF_W-1:0] d_x,
    output logic [HALF_W-1:0] d_y
);
    logic [HALF_W-1:0] b_hi, b_lo, c_hi, c_lo;

    assign b_hi = src_b[WORD_W-1:HALF_W];
    assign b_lo = src_b[HALF_W-1:0];
    assign c_hi = src_c[WORD_W-1:HALF_W];
    assign c_lo = src_c[HALF_W-1:0];

    always_comb begin
        unique case (dmac_sel_e'(sel))
            SEL_HH_LL: begin a_x = b_hi; a_y = c_hi; d_x = b_lo; d_y = c_lo; end
            SEL_LH_HL: begin a_x = b_lo; a_y = c_hi; d_x = b_hi; d_y = c_lo; end
            SEL_HH_HH: begin a_x = b_hi; a_y = c_hi; d_x = b_hi; d_y = c_hi; end
            SEL_LL_LL: begin a_x = b_lo; a_y = c_lo; d_x = b_lo; d_y = c_lo; end
            default:   begin a_x = b_hi; a_y = c_hi; d_x = b_lo; d_y = c_lo; end
        endcase
    end
endmodule

// File: rtl/dmac_lane.sv
module dmac_lane #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] y,
    input  logic [WORD_W-1:0] acc,
    input  logic              frac,
    input  logic              sub,
    output logic [WORD_W-1:0] sum
);
    logic signed [WORD_W-1:0] prod;
    logic        [WORD_W-1:0] scaled;

    always_comb begin
        prod   = $signed(x) * $signed(y);
        scaled = frac ? {prod[WORD_W-2:0], 1'b0} : prod;
        sum    = sub ? (acc - scaled) : (acc + scaled);
    end

    // R4: a doubled product always has a cleared LSB
    always_comb begin
        if (frac) begin
            p_frac_even_r4: assert (scaled[0] == 1'b0);
        end
    end
endmodule

// File: rtl/dmac_round.sv
module dmac_round #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] val_in,
    input  logic              rnd_en,
    input  logic              tie_even,
    output logic [WORD_W-1:0] val_out
);
    localparam logic [WORD_W-1:0] HALF_LSB = {{(WORD_W-1){1'b0}}, 1'b1} << (HALF_W-1);
    localparam logic [HALF_W:0]   TIE_PAT  = {2'b01, {(HALF_W-1){1'b0}}};

    logic is_tie;
    logic add_bias;

    always_comb begin
        is_tie   = (val_in[HALF_W:0] == TIE_PAT);
        add_bias = rnd_en && !(tie_even && is_tie);
        val_out  = add_bias ? (val_in + HALF_LSB) : val_in;
    end

    // R6: without rounding enabled the lane value leaves unchanged
    always_comb begin
        if (!rnd_en) begin
            p_no_round_r6: assert (val_out == val_in);
        end
    end

    // R9: an exact tie in even-rounding mode keeps its value; otherwise R8/R7 add half an LSB
    always_comb begin
        if (rnd_en) begin
            p_round_step_r9: assert ((val_out - val_in) == ((tie_even && val_in[HALF_W:0] == TIE_PAT) ? '0 : HALF_LSB));
        end
    end
endmodule

// File: rtl/dmac_q15.sv
module dmac_q15
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [5:0]        op,
    input  logic [1:0]        sel,
    input  logic [1:0]        acc_pat,
    input  logic [31:0]       ctrl,
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] src_c,
    input  logic [WORD_W-1:0] acc_a,
    input  logic [WORD_W-1:0] acc_d,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_d,
    output logic              we_a,
    output logic              we_d
);
    dmac_state_e state_q, state_d;

    logic              op_known, is_frac, is_pack, accept;
    logic [HALF_W-1:0] lx [LANES];
    logic [HALF_W-1:0] ly [LANES];
    logic [WORD_W-1:0] lacc [LANES];
    logic [WORD_W-1:0] lsum [LANES];
    logic [WORD_W-1:0] lrnd [LANES];
    logic [LANES-1:0]  lsub;
    logic [WORD_W-1:0] word_a, word_d;

    always_comb begin
        op_known = 1'b0;
        is_frac  = 1'b0;
        is_pack  = 1'b0;
        case (op)
            OP_INT:  op_known = 1'b1;
            OP_WIDE: begin op_known = 1'b1; is_frac = 1'b1; end
            OP_PACK: begin op_known = 1'b1; is_frac = 1'b1; is_pack = 1'b1; end
            default: op_known = 1'b0;
        endcase
        accept = issue && op_known;
    end

    dmac_opsel #(.HALF_W(HALF_W)) u_opsel (
        .sel   (sel),
        .src_b (src_b),
        .src_c (src_c),
        .a_x   (lx[0]),
        .a_y   (ly[0]),
        .d_x   (lx[1]),
        .d_y   (ly[1])
    );

    assign lacc[0] = acc_a;
    assign lacc[1] = acc_d;
    assign lsub[0] = acc_pat[1];
    assign lsub[1] = acc_pat[0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmac_lane #(.HALF_W(HALF_W)) u_lane (
            .x    (lx[g]),
            .y    (ly[g]),
            .acc  (lacc[g]),
            .frac (is_frac),
            .sub  (lsub[g]),
            .sum  (lsum[g])
        );
        dmac_round #(.HALF_W(HALF_W)) u_round (
            .val_in   (lsum[g]),
            .rnd_en   (is_frac && ctrl[CTRL_RND_BIT]),
            .tie_even (is_pack && !ctrl[CTRL_BIAS_BIT]),
            .val_out  (lrnd[g])
        );
    end

    always_comb begin
        if (is_pack) begin
            word_a = {lrnd[0][WORD_W-1:HALF_W], lrnd[1][WORD_W-1:HALF_W]};
            word_d = '0;
        end else begin
            word_a = lrnd[0];
            word_d = lrnd[1];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = accept ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_a <= '0;
            res_d <= '0;
            we_a  <= 1'b0;
            we_d  <= 1'b0;
        end else if (accept) begin
            res_a <= word_a;
            res_d <= word_d;
            we_a  <= 1'b1;
            we_d  <= !is_pack;
        end else begin
            we_a  <= 1'b0;
            we_d  <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

    p_accept_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && !we_a && !we_d));
    p_packed_one_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PACK) |=> (we_a && !we_d));
    p_wide_two_dest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op != OP_PACK) |=> (we_a && we_d));
endmodule

// File: tb/tb_dmac_q15.sv
module tb_dmac_q15;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [5:0]  op = 6'h0;
    logic [1:0]  sel = 2'd0;
    logic [1:0]  acc_pat = 2'd0;
    logic [31:0] ctrl = 32'h0;
    logic [31:0] src_b = 32'h0, src_c = 32'h0, acc_a = 32'h0, acc_d = 32'h0;
    logic        out_valid, we_a, we_d;
    logic [31:0] res_a, res_d;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dmac_q15 dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .sel(sel),
        .acc_pat(acc_pat), .ctrl(ctrl), .src_b(src_b), .src_c(src_c),
        .acc_a(acc_a), .acc_d(acc_d), .out_valid(out_valid),
        .res_a(res_a), .res_d(res_d), .we_a(we_a), .we_d(we_d)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mulq(logic [15:0] x, logic [15:0] y, logic f);
        logic signed [31:0] p;
        p = $signed(x) * $signed(y);
        return f ? (p << 1) : p;
    endfunction

    function automatic logic [31:0] rnd(logic [31:0] v, logic en, logic even);
        if (!en) return v;
        if (even && v[16:0] == 17'h08000) return v;
        return v + 32'h8000;
    endfunction

    // one operation: drive, check results the cycle after, then check the pulse ends
    task automatic run_op(string req, logic [5:0] o, logic [1:0] s, logic [1:0] pat,
                          logic [31:0] cw, logic [31:0] b, logic [31:0] c,
                          logic [31:0] a, logic [31:0] d);
        logic f, pk;
        logic [15:0] ax, ay, dx, dy;
        logic [31:0] la, ld, ea, ed;
        f  = (o == 6'h0F) || (o == 6'h0B);
        pk = (o == 6'h0B);
        case (s)
            2'd0: begin ax = b[31:16]; ay = c[31:16]; dx = b[15:0];  dy = c[15:0]; end
            2'd1: begin ax = b[15:0];  ay = c[31:16]; dx = b[31:16]; dy = c[15:0]; end
            2'd2: begin ax = b[31:16]; ay = c[31:16]; dx = b[31:16]; dy = c[31:16]; end
            default: begin ax = b[15:0]; ay = c[15:0]; dx = b[15:0]; dy = c[15:0]; end
        endcase
        la = pat[1] ? a - mulq(ax, ay, f) : a + mulq(ax, ay, f);
        ld = pat[0] ? d - mulq(dx, dy, f) : d + mulq(dx, dy, f);
        la = rnd(la, f && cw[1], pk && !cw[2]);
        ld = rnd(ld, f && cw[1], pk && !cw[2]);
        if (pk) begin ea = {la[31:16], ld[31:16]}; ed = 32'h0; end
        else begin ea = la; ed = ld; end
        @(negedge clk);
        op = o; sel = s; acc_pat = pat; ctrl = cw;
        src_b = b; src_c = c; acc_a = a; acc_d = d; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check({req, " R12 valid"}, {31'b0, out_valid}, 32'h1);
        check({req, " res_a"}, res_a, ea);
        if (!pk) check({req, " R11 res_d"}, res_d, ed);
        check({req, " we_a"}, {31'b0, we_a}, 32'h1);
        check({req, pk ? " R10 we_d" : " R11 we_d"}, {31'b0, we_d}, {31'b0, !pk});
        @(negedge clk);
        check({req, " R12 pulse end"}, {31'b0, out_valid}, 32'h0);
    endtask

    task automatic t_reset();
        check("R12 reset valid", {31'b0, out_valid}, 32'h0);
        check("R12 reset res_a", res_a, 32'h0);
        check("R12 reset res_d", res_d, 32'h0);
        check("R12 reset we", {30'b0, we_a, we_d}, 32'h0);
    endtask

    task automatic t_integer();
        run_op("R3 int add",   6'h0A, 2'd0, 2'b00, 32'h6, 32'h0003FFFE, 32'h00050007, 32'd100, 32'd100);
        run_op("R5 int sub",   6'h0A, 2'd0, 2'b11, 32'h0, 32'h0003FFFE, 32'h00050007, 32'd100, 32'd100);
        run_op("R5 int mixed", 6'h0A, 2'd0, 2'b10, 32'h0, 32'h80007FFF, 32'h80008000, 32'hFFFFFFFF, 32'h7FFFFFFF);
    endtask

    task automatic t_select();
        run_op("R2 sel1", 6'h0A, 2'd1, 2'b00, 32'h0, 32'h1234FF00, 32'hFFF30011, 32'h0, 32'h0);
        run_op("R2 sel2", 6'h0A, 2'd2, 2'b00, 32'h0, 32'h1234FF00, 32'hFFF30011, 32'h0, 32'h0);
        run_op("R2 sel3", 6'h0A, 2'd3, 2'b01, 32'h0, 32'h1234FF00, 32'hFFF30011, 32'h0, 32'h0);
    endtask

    task automatic t_fractional();
        run_op("R4 wide nornd R6", 6'h0F, 2'd0, 2'b00, 32'h0, 32'h80004000, 32'h80004000, 32'h0, 32'h5);
        run_op("R7 wide rnd",      6'h0F, 2'd0, 2'b01, 32'h2, 32'h00010003, 32'h7FFF0005, 32'h00008000, 32'h1);
        run_op("R7 wide rnd bias", 6'h0F, 2'd0, 2'b00, 32'h6, 32'h0, 32'h0, 32'h00008000, 32'h00018000);
    endtask

    task automatic t_packed();
        run_op("R9 pack even",   6'h0B, 2'd0, 2'b00, 32'h2, 32'h0, 32'h0, 32'h00018000, 32'h00008000);
        run_op("R8 pack bias",   6'h0B, 2'd0, 2'b00, 32'h6, 32'h0, 32'h0, 32'h00018000, 32'h00008000);
        run_op("R6 pack norm",   6'h0B, 2'd0, 2'b00, 32'h0, 32'h0, 32'h0, 32'h00018000, 32'h00008000);
        run_op("R10 pack layout", 6'h0B, 2'd1, 2'b10, 32'h2, 32'h40002000, 32'hC0001234, 32'h12345678, 32'h9ABCDEF0);
    endtask

    task automatic t_reject();
        @(negedge clk);
        op = 6'h0C; issue = 1'b1;
        @(negedge clk);
        check("R1 bad op valid", {31'b0, out_valid}, 32'h0);
        check("R1 bad op we", {30'b0, we_a, we_d}, 32'h0);
        op = 6'h0A; issue = 1'b0;
        @(negedge clk);
        check("R1 no issue valid", {31'b0, out_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_integer();
        t_select();
        t_fractional();
        t_packed();
        t_reject();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule